// File: doc/BRIEF.md
# Sparse XOR-Matrix Uniform Random Bit Generator

This block produces uniformly distributed random bits from a binary linear recurrence. An N-bit state register advances on every enabled clock by multiplying it with a fixed transition matrix over GF(2). In that arithmetic, AND is the product and XOR is the sum. The matrix is sparse: every row and every column holds T-1 or T ones. Each next-state bit is therefore a single XOR of at most T current bits, which fits one small lookup table. There is no carry chain and no long feedback path.

An output matrix maps the state to R output bits. With the identity variant (the default), the state is emitted directly. Otherwise, each output bit is the XOR of any chosen subset of state bits, so state bits may be dropped or folded together. Both matrices are packed parameter vectors. When the transition matrix has a primitive characteristic polynomial, the state walks through every nonzero N-bit pattern before it repeats. The default matrix meets that condition for N = 6, T = 3. Only the all-zero state is excluded, and the block keeps the state out of it.

A small controller has two named states. PRIMED means the state is freshly seeded and the output is not yet valid. RUN means at least one step has been taken. The transitions are:
- SEED: reset or a seed load, from any state, to PRIMED.
- STEP: enable without load, from any state, to RUN.
- IDLE: neither enable nor load; the controller stays where it is.

Top module: `sxr_urng`

## Requirements
- R1: Synchronous reset loads the state with SEED_DEFAULT (default 6'h15) and drives valid_o low. rnd_o then shows the output-matrix image of that seed.
- R2: On a clock with en_i high and seed_ld_i low, next-state bit i becomes the XOR of the current state bits j for which A_MATRIX bit i*N+j is 1. For the default matrix the rows are:
  - b0 = x0^x1^x3
  - b1 = x2^x3^x4
  - b2 = x3^x4^x5
  - b3 = x0^x4^x5
  - b4 = x1^x5
  - b5 = x0^x2
- R3: rnd_o is combinational from the state register. Bit k is the XOR of the state bits j for which B_MATRIX bit k*N+j is 1. With USE_IDENTITY=1, bit k equals state bit k.
- R4: With en_i and seed_ld_i both low, the state, rnd_o and valid_o hold their values.
- R5: A clock with seed_ld_i high loads seed_i into the state, even when en_i is also high. It also drives valid_o low.
- R6: A loaded seed of all zeros is replaced by ZERO_FILL (default 6'h20), which is nonzero.
- R7: valid_o rises on the first enabled clock after a reset or a seed load. It stays high while only steps and holds follow.
- R8: Outside reset, the state is never all zeros.
- R9: With the default matrix and any nonzero seed, 63 consecutive steps visit 63 distinct nonzero states and then return to the starting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the recurrence by one step |
| seed_ld_i | input | 1 | Load seed_i into the state |
| seed_i | input | N | Seed value |
| rnd_o | output | R | Random output bits |
| valid_o | output | 1 | Output holds at least one stepped value |

## Verification
The bench builds two instances on the same inputs. One uses the default 6-bit matrix with the identity output map, which makes the state visible at the ports. The other keeps the same 6-bit state but folds it into 3 outputs through a non-identity matrix. With a 6-bit state the whole 63-step cycle is short enough to walk completely, so the period, the absence of early repeats and the nonzero property are checked exhaustively. A software matrix model runs in lockstep with both instances. The first instance checks the transition matrix and the second checks the folded output map.

// File: rtl/sxr_pkg.sv
package sxr_pkg;

    // Controller phase: PRIMED after a seed, RUN after at least one step
    typedef enum logic [0:0] {
        ST_PRIMED = 1'b0,
        ST_RUN    = 1'b1
    } sxr_phase_e;

    // Controller decision for the state register in the current cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEED = 2'd1,
        ACT_STEP = 2'd2
    } sxr_act_e;

endpackage

// File: rtl/sxr_step.sv
// One recurrence step: each next bit is the GF(2) product of one matrix row
// with the current state, i.e. a narrow XOR of the selected bits.
module sxr_step #(
    parameter int N = 6,
    parameter logic [N*N-1:0] A_MATRIX = '0
) (
    input  logic [N-1:0] cur_i,
    output logic [N-1:0] nxt_o
);
    for (genvar i = 0; i < N; i++) begin : g_row
        assign nxt_o[i] = ^(cur_i & A_MATRIX[i*N +: N]);
    end
endmodule

// File: rtl/sxr_mix.sv
// Output map: identity variant or a general R-by-N XOR matrix.
module sxr_mix #(
    parameter int N = 6,
    parameter int R = 6,
    parameter bit USE_IDENTITY = 1'b1,
    parameter logic [R*N-1:0] B_MATRIX = '0
) (
    input  logic [N-1:0] st_i,
    output logic [R-1:0] out_o
);
    if (USE_IDENTITY) begin : g_ident
        assign out_o = st_i[R-1:0];
    end else begin : g_matrix
        for (genvar k = 0; k < R; k++) begin : g_out
            assign out_o[k] = ^(st_i & B_MATRIX[k*N +: N]);
        end
    end
endmodule

// File: rtl/sxr_ctrl.sv
// Phase controller. Transitions: SEED (reset or load -> PRIMED),
// STEP (enable -> RUN), IDLE (stay).
module sxr_ctrl
    import sxr_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     en_i,
    input  logic     seed_ld_i,
    output sxr_act_e act_o,
    output logic     valid_o
);
    sxr_phase_e phase_q, phase_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= ST_PRIMED;
        else       phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        act_o   = ACT_HOLD;
        unique case (phase_q)
            ST_PRIMED: begin
                if (seed_ld_i) begin
                    act_o = ACT_SEED;
                end else if (en_i) begin
                    act_o   = ACT_STEP;
                    phase_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (seed_ld_i) begin
                    act_o   = ACT_SEED;
                    phase_d = ST_PRIMED;
                end else if (en_i) begin
                    act_o = ACT_STEP;
                end
            end
            default: phase_d = ST_PRIMED;
        endcase
    end

    always_comb begin
        valid_o = (phase_q == ST_RUN);
    end
endmodule

// File: rtl/sxr_urng.sv
module sxr_urng
    import sxr_pkg::*;
#(
    parameter int N = 6,
    parameter int R = 6,
    parameter int T = 3,
    parameter logic [N*N-1:0] A_MATRIX =
        36'b000101_100010_110001_111000_011100_001011,
    parameter bit USE_IDENTITY = 1'b1,
    parameter logic [R*N-1:0] B_MATRIX = '0,
    parameter logic [N-1:0] SEED_DEFAULT = 6'h15,
    parameter logic [N-1:0] ZERO_FILL = 6'h20
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         seed_ld_i,
    input  logic [N-1:0] seed_i,
    output logic [R-1:0] rnd_o,
    output logic         valid_o
);
    // Fan-in bound per next-state bit; kept for documentation of the matrix class
    localparam int MAX_FANIN = T;

    sxr_act_e     act;
    logic [N-1:0] state_q;
    logic [N-1:0] step_nxt;
    logic [N-1:0] seed_clean;

    sxr_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .seed_ld_i(seed_ld_i),
        .act_o    (act),
        .valid_o  (valid_o)
    );

    sxr_step #(.N(N), .A_MATRIX(A_MATRIX)) u_step (
        .cur_i(state_q),
        .nxt_o(step_nxt)
    );

    always_comb begin
        seed_clean = (seed_i == '0) ? ZERO_FILL : seed_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEED_DEFAULT;
        end else begin
            unique case (act)
                ACT_SEED: state_q <= seed_clean;
                ACT_STEP: state_q <= step_nxt;
                default:  state_q <= state_q;
            endcase
        end
    end

    sxr_mix #(
        .N(N), .R(R), .USE_IDENTITY(USE_IDENTITY), .B_MATRIX(B_MATRIX)
    ) u_mix (
        .st_i (state_q),
        .out_o(rnd_o)
    );

    if (MAX_FANIN < 2) begin : g_fanin_note
        // A fan-in below two cannot mix state; the matrix class assumes T >= 2
    end
endmodule

// File: rtl/sxr_urng_chk.sv
module sxr_urng_chk #(
    parameter int N = 6,
    parameter int R = 6,
    parameter logic [N-1:0] ZERO_FILL = 6'h20
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         en_i,
    input logic         seed_ld_i,
    input logic [N-1:0] seed_i,
    input logic [R-1:0] rnd_o,
    input logic         valid_o,
    input logic [N-1:0] state_q
);
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !seed_ld_i) |=> ($stable(rnd_o) && $stable(valid_o) && $stable(state_q)));

    assert_load_value_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_ld_i && seed_i != '0) |=> (state_q == $past(seed_i) && !valid_o));

    assert_zero_seed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_ld_i && seed_i == '0) |=> (state_q == ZERO_FILL));

    assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !seed_ld_i) |=> valid_o);

    assert_nonzero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != '0);
endmodule

bind sxr_urng sxr_urng_chk #(.N(N), .R(R), .ZERO_FILL(ZERO_FILL)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .seed_ld_i(seed_ld_i),
    .seed_i   (seed_i),
    .rnd_o    (rnd_o),
    .valid_o  (valid_o),
    .state_q  (state_q)
);

// File: tb/sxr_urng_tb_top.sv
`timescale 1ns/1ps
module sxr_urng_tb_top;
    localparam int N = 6;
    localparam logic [N*N-1:0] TB_A = 36'b000101_100010_110001_111000_011100_001011;
    localparam logic [3*N-1:0] TB_B = 18'b011000_000110_100001;

    typedef struct packed {
        logic       ld;
        logic       en;
        logic [5:0] seed;
        logic [5:0] exp_out;
        logic       exp_vld;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 6'h00, 6'h05, 1'b1},  // R2 R7 step from 0x15
        '{1'b0, 1'b0, 6'h00, 6'h05, 1'b1},  // R4 hold
        '{1'b0, 1'b1, 6'h00, 6'h0B, 1'b1},  // R2
        '{1'b0, 1'b1, 6'h00, 6'h3F, 1'b1},  // R2
        '{1'b0, 1'b0, 6'h3A, 6'h3F, 1'b1},  // R4 seed ignored without load
        '{1'b0, 1'b1, 6'h00, 6'h0F, 1'b1},  // R2
        '{1'b1, 1'b1, 6'h01, 6'h01, 1'b0},  // R5 load beats enable
        '{1'b0, 1'b0, 6'h00, 6'h01, 1'b0},  // R4 R7 valid stays low
        '{1'b0, 1'b1, 6'h00, 6'h29, 1'b1},  // R2 R7
        '{1'b1, 1'b0, 6'h00, 6'h20, 1'b0},  // R6 zero seed
        '{1'b0, 1'b1, 6'h00, 6'h1C, 1'b1}   // R2 from fill
    };

    logic clk = 1'b0;
    logic rst, en, ld;
    logic [N-1:0] seed;
    logic [N-1:0] out_a;
    logic [2:0]   out_b;
    logic         vld_a, vld_b;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sxr_urng dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .seed_ld_i(ld),
        .seed_i(seed), .rnd_o(out_a), .valid_o(vld_a)
    );

    sxr_urng #(.R(3), .USE_IDENTITY(1'b0), .B_MATRIX(TB_B)) dut_fold_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .seed_ld_i(ld),
        .seed_i(seed), .rnd_o(out_b), .valid_o(vld_b)
    );

    function automatic logic [N-1:0] mdl_step(input logic [N-1:0] x);
        logic [N-1:0] y;
        for (int i = 0; i < N; i++) begin
            y[i] = 1'b0;
            for (int j = 0; j < N; j++) y[i] ^= TB_A[i*N+j] & x[j];
        end
        return y;
    endfunction

    function automatic logic [2:0] mdl_fold(input logic [N-1:0] x);
        logic [2:0] y;
        for (int k = 0; k < 3; k++) begin
            y[k] = 1'b0;
            for (int j = 0; j < N; j++) y[k] ^= TB_B[k*N+j] & x[j];
        end
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic e, input logic [N-1:0] s);
        ld = l; en = e; seed = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] mst;
        logic [N-1:0] start;
        bit seen [64];
        int repeats;
        rst = 1'b1; en = 1'b1; ld = 1'b0; seed = '0;
        repeat (3) @(negedge clk);
        // R1 reset state, even with enable high during reset
        check("R1 out", {26'b0, out_a}, 32'h15);
        check("R1 valid", {31'b0, vld_a}, 32'h0);
        check("R1 R3 folded", {29'b0, out_b}, {29'b0, mdl_fold(6'h15)});
        rst = 1'b0;
        en = 1'b0;

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].ld, VECS[v].en, VECS[v].seed);
            check($sformatf("R2-R7 vector %0d out", v), {26'b0, out_a}, {26'b0, VECS[v].exp_out});
            check($sformatf("R7 vector %0d valid", v), {31'b0, vld_a}, {31'b0, VECS[v].exp_vld});
            check($sformatf("R3 vector %0d folded", v), {29'b0, out_b}, {29'b0, mdl_fold(VECS[v].exp_out)});
        end

        // R9 R8 exhaustive period walk with lockstep model, from seed 0x2D
        drive(1'b1, 1'b0, 6'h2D);
        start = 6'h2D;
        mst = start;
        for (int k = 0; k < 64; k++) seen[k] = 1'b0;
        seen[start] = 1'b1;
        repeats = 0;
        for (int s = 1; s <= 63; s++) begin
            drive(1'b0, 1'b1, '0);
            mst = mdl_step(mst);
            check("R2 lockstep", {26'b0, out_a}, {26'b0, mst});
            check("R3 lockstep folded", {29'b0, out_b}, {29'b0, mdl_fold(mst)});
            if (s < 63) begin
                if (out_a == '0 || seen[out_a]) repeats++;
                seen[out_a] = 1'b1;
            end
        end
        check("R9 R8 no early repeat or zero", repeats, 0);
        check("R9 period returns to start", {26'b0, out_a}, {26'b0, start});

        // R1 reset again mid-run
        drive(1'b0, 1'b1, '0);
        rst = 1'b1;
        drive(1'b0, 1'b1, '0);
        check("R1 re-reset out", {26'b0, out_a}, 32'h15);
        check("R1 R7 re-reset valid", {31'b0, vld_a}, 32'h0);
        rst = 1'b0;
        drive(1'b0, 1'b1, '0);
        check("R7 first step after reset", {31'b0, vld_a}, 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule